// File: doc/BRIEF.md
# Frame-Sync Clocked Serial Byte Transmitter

This block sends display identification data one way, with no address phase. Once the mode bit is enabled, every rising edge of an external vertical-sync input moves the serial data line on to the next bit of a byte shift register. The data line is open-drain: the block pulls it low for a zero bit and releases it for a one bit. Bits go out most significant bit first. Each byte takes nine sync edges: eight data bits, then one slot in which the line is released. The ninth edge sets a byte-done flag and loads the next byte from a one-byte buffer.

The CPU writes the next byte into that buffer at any time. A write during a byte does not disturb the byte in flight. If no new byte arrives before the byte ends, the buffered byte is sent again. A control write sets the mode bit and the flag's interrupt enable. The status outputs show the flag, both control bits and a read/write bit. The read/write bit reads one while the mode is on. An interrupt request is raised only when the flag, its enable and the global interrupt-enable input are all high.

Top module: `vsync_tx_shifter`

## Requirements
- R1: After reset, sda_pull_low, stat_byte_done, irq_req, stat_mode_en, stat_irq_en and stat_rw are all 0.
- R2: While the mode is on, the current bit sits on the line with sda_pull_low = 1 for a 0 bit and 0 for a 1 bit. Bits go out in order from bit 7 down to bit 0, and each rising sync edge moves to the next bit.
- R3: After the eighth edge of a byte, the line is released (sda_pull_low = 0) for one slot. The ninth edge sets stat_byte_done and starts the next byte at bit 7, taken from the buffer.
- R4: If no byte is written during a byte, the same byte value is sent again.
- R5: A byte write during a transfer leaves the rest of the current byte unchanged and takes effect at the next byte boundary.
- R6: stat_rw reads 1 while the mode is on and 0 while it is off.
- R7: A control write that clears the mode bit also clears stat_byte_done and releases the line. Sync edges while the mode is off have no effect.
- R8: irq_req is 1 exactly when stat_byte_done, stat_irq_en and gie are all 1.
- R9: A pulse on flag_clr clears stat_byte_done. If a byte completes in the same cycle, the flag is set.
- R10: The sync input passes through two synchronizer flops, and only a rising edge is acted on. The line changes at the third rising clock edge after the sync input rises. Holding the sync input high advances only one bit.
- R11: Turning the mode on loads the buffered byte, or the byte being written in that cycle, and starts at bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vsync_async | input | 1 | Asynchronous vertical-sync bit clock |
| data_wr | input | 1 | Strobe that writes data_in into the next-byte buffer |
| data_in | input | 8 | Next byte to transmit |
| ctrl_wr | input | 1 | Strobe that writes the control bits |
| ctrl_mode_en | input | 1 | Mode-enable value for a control write |
| ctrl_irq_en | input | 1 | Flag interrupt enable value for a control write |
| flag_clr | input | 1 | Clears the byte-done flag |
| gie | input | 1 | Global interrupt enable |
| sda_pull_low | output | 1 | Open-drain data line drive (1 pulls the line low) |
| stat_mode_en | output | 1 | Current mode-enable bit |
| stat_irq_en | output | 1 | Current flag interrupt enable |
| stat_byte_done | output | 1 | Byte-done flag |
| stat_rw | output | 1 | Read/write status bit |
| irq_req | output | 1 | Interrupt request |

## Verification
A wrong bit counter or shift register shows up as a wrong level on sda_pull_low within one sync edge. It can appear as a missing release slot, a shifted bit order, or a flag rising on the wrong edge. A lost buffer update shows at the next byte boundary, when the old byte is sent again. A fault in the synchronizer timing shows within three clock cycles of a sync rise, because the line then moves one cycle early or late.

// File: rtl/vts_pkg.sv
package vts_pkg;
    // Byte width of the transmitter
    localparam int unsigned VTS_DATA_W = 8;
    // Synchronizer depth for the sync input
    localparam int unsigned VTS_SYNC_STAGES = 2;

    // Control register contents
    typedef struct packed {
        logic mode;
        logic irq_en;
    } vts_cfg_t;
endpackage

// File: rtl/vts_edge_sync.sv
// Synchronizes an asynchronous input through SYNC_STAGES flops and
// produces a one-cycle pulse on each rising edge of the synchronized
// value. Assumes the input stays low during reset.
module vts_edge_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_pulse
);
    localparam int unsigned CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain_q;

    // First stage samples the raw input
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q[0] <= 1'b0;
        else        chain_q[0] <= async_in;
    end

    genvar gi;
    generate
        for (gi = 1; gi < CHAIN_W; gi++) begin : g_stage
            // Each further stage delays the previous stage by one cycle
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[gi] <= 1'b0;
                else        chain_q[gi] <= chain_q[gi-1];
            end
        end
    endgenerate

    // Rising edge: synchronized output high, delayed copy still low
    assign rise_pulse = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
endmodule

// File: rtl/vts_byte_shifter.sv
// Holds the next-byte buffer and the transmit shift register and
// counts the bit slots of each byte. Slots 0..DATA_W-1 carry data,
// MSB first; slot DATA_W releases the line. Assumes start and adv
// never occur together (start only fires while the mode is off).
module vts_byte_shifter #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_wr,
    input  logic [DATA_W-1:0] load_data,
    input  logic              start,
    input  logic              adv,
    input  logic              active,
    output logic              pull_low,
    output logic              byte_done,
    output logic [CNT_W-1:0]  slot_cnt
);
    localparam int unsigned CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(DATA_W);

    logic [DATA_W-1:0] hold_q;
    logic [DATA_W-1:0] hold_d;
    logic [DATA_W-1:0] shreg_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              in_ack;

    // Buffer value including a write made in this same cycle
    assign hold_d = load_wr ? load_data : hold_q;

    // Next-byte buffer keeps the last written byte
    always_ff @(posedge clk) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    assign in_ack    = (cnt_q == LAST_SLOT);
    assign byte_done = adv & in_ack;

    // Shift register and slot counter advance on each sync edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
            cnt_q   <= '0;
        end else if (start) begin
            shreg_q <= hold_d;
            cnt_q   <= '0;
        end else if (adv) begin
            if (in_ack) begin
                shreg_q <= hold_d;
                cnt_q   <= '0;
            end else begin
                shreg_q <= {shreg_q[DATA_W-2:0], 1'b0};
                cnt_q   <= cnt_q + 1'b1;
            end
        end
    end

    // Pull low only for a zero data bit while active
    assign pull_low = active & ~in_ack & ~shreg_q[DATA_W-1];
    assign slot_cnt = cnt_q;
endmodule

// File: rtl/vts_ctrl.sv
// Control bits, byte-done flag and interrupt request. Clearing the
// mode clears the flag; a completed byte beats a clear pulse.
module vts_ctrl
    import vts_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ctrl_wr,
    input  logic     wr_mode,
    input  logic     wr_irq_en,
    input  logic     flag_clr,
    input  logic     byte_done,
    input  logic     gie,
    output vts_cfg_t cfg,
    output logic     start,
    output logic     flag,
    output logic     irq
);
    vts_cfg_t cfg_q;
    logic     flag_q;

    // Control register written by the CPU
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (ctrl_wr) begin
            cfg_q.mode   <= wr_mode;
            cfg_q.irq_en <= wr_irq_en;
        end
    end

    // Start pulse when the mode turns on
    assign start = ctrl_wr & wr_mode & ~cfg_q.mode;

    // Byte-done flag: disable clears, completion sets, clear pulse clears
    always_ff @(posedge clk) begin
        if (!rst_n)                    flag_q <= 1'b0;
        else if (ctrl_wr && !wr_mode)  flag_q <= 1'b0;
        else if (byte_done)            flag_q <= 1'b1;
        else if (flag_clr)             flag_q <= 1'b0;
    end

    assign cfg  = cfg_q;
    assign flag = flag_q;
    assign irq  = flag_q & cfg_q.irq_en & gie;
endmodule

// File: rtl/vsync_tx_shifter.sv
// Top level: a one-way serial byte transmitter clocked by rising edges
// of an external vertical-sync input, with no address phase.
module vsync_tx_shifter
    import vts_pkg::*;
#(
    parameter int unsigned DATA_W      = VTS_DATA_W,
    parameter int unsigned SYNC_STAGES = VTS_SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vsync_async,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] data_in,
    input  logic              ctrl_wr,
    input  logic              ctrl_mode_en,
    input  logic              ctrl_irq_en,
    input  logic              flag_clr,
    input  logic              gie,
    output logic              sda_pull_low,
    output logic              stat_mode_en,
    output logic              stat_irq_en,
    output logic              stat_byte_done,
    output logic              stat_rw,
    output logic              irq_req
);
    localparam int unsigned CNT_W = $clog2(DATA_W + 1);

    vts_cfg_t         cfg;
    logic             sync_rise;
    logic             adv;
    logic             start;
    logic             byte_done;
    logic [CNT_W-1:0] bit_cnt;

    vts_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .async_in  (vsync_async),
        .rise_pulse(sync_rise)
    );

    // Edges only count while the mode is on
    assign adv = sync_rise & cfg.mode;

    vts_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_wr  (ctrl_wr),
        .wr_mode  (ctrl_mode_en),
        .wr_irq_en(ctrl_irq_en),
        .flag_clr (flag_clr),
        .byte_done(byte_done),
        .gie      (gie),
        .cfg      (cfg),
        .start    (start),
        .flag     (stat_byte_done),
        .irq      (irq_req)
    );

    vts_byte_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_wr  (data_wr),
        .load_data(data_in),
        .start    (start),
        .adv      (adv),
        .active   (cfg.mode),
        .pull_low (sda_pull_low),
        .byte_done(byte_done),
        .slot_cnt (bit_cnt)
    );

    assign stat_mode_en = cfg.mode;
    assign stat_irq_en  = cfg.irq_en;
    // Read/write status is forced to one in this transmit-only mode
    assign stat_rw      = cfg.mode;
endmodule

// File: rtl/vts_checker.sv
// Property checks for vsync_tx_shifter, attached by bind.
module vts_checker #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CNT_W  = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sda_pull_low,
    input logic             stat_mode_en,
    input logic             stat_irq_en,
    input logic             stat_byte_done,
    input logic             stat_rw,
    input logic             irq_req,
    input logic             gie,
    input logic             adv,
    input logic             byte_done,
    input logic [CNT_W-1:0] bit_cnt
);
    a_r7_off_released: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_mode_en |-> !sda_pull_low);

    a_r6_rw_when_on: assert property (@(posedge clk) disable iff (!rst_n)
        stat_mode_en |-> stat_rw);

    a_r7_flag_drops_on_disable: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_mode_en) |-> !stat_byte_done);

    a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (stat_byte_done && stat_irq_en && gie));

    a_r3_ack_released: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_cnt == CNT_W'(DATA_W)) |-> !sda_pull_low);

    a_r3_flag_from_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_byte_done) |-> $past(byte_done));

    a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(DATA_W));

    a_r2_cnt_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && bit_cnt < CNT_W'(DATA_W)) |=> (bit_cnt == $past(bit_cnt) + 1'b1));

    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> !adv);
endmodule

bind vsync_tx_shifter vts_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sda_pull_low  (sda_pull_low),
    .stat_mode_en  (stat_mode_en),
    .stat_irq_en   (stat_irq_en),
    .stat_byte_done(stat_byte_done),
    .stat_rw       (stat_rw),
    .irq_req       (irq_req),
    .gie           (gie),
    .adv           (adv),
    .byte_done     (byte_done),
    .bit_cnt       (bit_cnt)
);

// File: tb/vsync_tx_shifter_tb.sv
module vsync_tx_shifter_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vsync_async = 1'b0;
    logic data_wr = 1'b0;
    logic [7:0] data_in = '0;
    logic ctrl_wr = 1'b0, ctrl_mode_en = 1'b0, ctrl_irq_en = 1'b0;
    logic flag_clr = 1'b0, gie = 1'b0;
    logic sda_pull_low, stat_mode_en, stat_irq_en, stat_byte_done, stat_rw, irq_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Model state
    logic [7:0] m_hold = '0, m_sh = '0;
    int m_cnt = 0;
    logic m_mode = 0, m_ien = 0, m_flag = 0;

    always #4 clk = ~clk;

    vsync_tx_shifter u_dut (
        .clk(clk), .rst_n(rst_n), .vsync_async(vsync_async),
        .data_wr(data_wr), .data_in(data_in), .ctrl_wr(ctrl_wr),
        .ctrl_mode_en(ctrl_mode_en), .ctrl_irq_en(ctrl_irq_en),
        .flag_clr(flag_clr), .gie(gie), .sda_pull_low(sda_pull_low),
        .stat_mode_en(stat_mode_en), .stat_irq_en(stat_irq_en),
        .stat_byte_done(stat_byte_done), .stat_rw(stat_rw), .irq_req(irq_req)
    );

    function automatic logic exp_line(logic mode, int cnt, logic [7:0] sh);
        return mode && (cnt < 8) && !sh[7];
    endfunction

    function automatic logic exp_irq(logic flag, logic ien, logic g);
        return flag & ien & g;
    endfunction

    task automatic check(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic check_all(string req);
        check({req, " line"}, sda_pull_low, exp_line(m_mode, m_cnt, m_sh));
        check({req, " flag"}, stat_byte_done, m_flag);
        check({req, " R8 irq"}, irq_req, exp_irq(m_flag, m_ien, gie));
        check({req, " R6 rw"}, stat_rw, m_mode);
    endtask

    task automatic do_ctrl(logic mode, logic ien);
        @(negedge clk);
        ctrl_wr = 1; ctrl_mode_en = mode; ctrl_irq_en = ien;
        @(negedge clk);
        ctrl_wr = 0;
        if (mode && !m_mode) begin m_sh = m_hold; m_cnt = 0; end
        if (!mode) m_flag = 0;
        m_mode = mode; m_ien = ien;
    endtask

    task automatic do_write(logic [7:0] d);
        @(negedge clk);
        data_wr = 1; data_in = d;
        @(negedge clk);
        data_wr = 0;
        m_hold = d;
    endtask

    task automatic model_edge();
        if (m_mode) begin
            if (m_cnt == 8) begin m_flag = 1; m_sh = m_hold; m_cnt = 0; end
            else begin m_sh = m_sh << 1; m_cnt++; end
        end
    endtask

    task automatic do_edge();
        @(negedge clk);
        vsync_async = 1;
        repeat (4) @(negedge clk);
        vsync_async = 0;
        repeat (3) @(negedge clk);
        model_edge();
    endtask

    initial begin
        #800000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 line", sda_pull_low, 0);
        check("R1 flag", stat_byte_done, 0);
        check("R1 irq", irq_req, 0);
        check("R1 mode", stat_mode_en, 0);
        check("R1 ien", stat_irq_en, 0);
        check("R1 rw", stat_rw, 0);

        // R7 edges while off do nothing
        do_edge(); do_edge();
        check_all("R7 off");

        // R11 enable loads buffered byte at MSB
        do_write(8'hA5);
        do_ctrl(1, 1);
        gie = 1;
        check_all("R11 start");
        check("R11 msb A5 bit7=1", sda_pull_low, 0);

        // R10 latency: bit7=1 -> bit6=0 on third clock after rise
        @(negedge clk); vsync_async = 1;
        @(negedge clk); @(negedge clk);
        check("R10 no change after two clocks", sda_pull_low, 0);
        @(negedge clk);
        check("R10 change on third clock", sda_pull_low, 1);
        repeat (6) @(negedge clk);
        check("R10 held high advances once", sda_pull_low, 1);
        vsync_async = 0; repeat (3) @(negedge clk);
        model_edge();
        check_all("R10 after");

        // R2/R5: write mid-byte, current byte unaffected
        do_write(8'h3C);
        for (int i = 0; i < 7; i++) begin do_edge(); check_all("R2 R5 bit"); end
        check("R3 ack slot released", sda_pull_low, 0);
        do_edge();
        check_all("R3 boundary");
        check("R3 flag set", stat_byte_done, 1);
        check("R5 new byte bit7 of 3C", sda_pull_low, 1);

        // R9 clear, and set wins in the same cycle
        @(negedge clk); flag_clr = 1; @(negedge clk); flag_clr = 0; m_flag = 0;
        check_all("R9 clear");
        for (int i = 0; i < 8; i++) do_edge();
        @(negedge clk); vsync_async = 1;
        @(negedge clk); @(negedge clk);
        flag_clr = 1;
        @(negedge clk); flag_clr = 0;
        repeat (3) @(negedge clk); vsync_async = 0; repeat (3) @(negedge clk);
        model_edge();
        check("R9 set wins", stat_byte_done, 1);
        // R4 retransmit 3C
        check_all("R4 resend");
        check("R4 resend bit7 of 3C", sda_pull_low, 1);

        // R7 disable clears flag
        do_ctrl(0, 1);
        check_all("R7 disable");
        check("R7 flag cleared", stat_byte_done, 0);

        // Random phase
        do_ctrl(1, 1);
        for (int i = 0; i < 400; i++) begin
            int op;
            op = $urandom_range(0, 99);
            if (op < 60) do_edge();
            else if (op < 78) do_write(8'($urandom));
            else if (op < 84) begin
                @(negedge clk); flag_clr = 1; @(negedge clk); flag_clr = 0;
                m_flag = 0;
            end else if (op < 92) begin
                @(negedge clk); gie = 1'($urandom);
                @(negedge clk);
            end else if (op < 97) do_ctrl(1'($urandom), 1'($urandom));
            else do_ctrl(!m_mode, m_ien);
            check_all("R2 R3 R4 R5 R8 random");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule